// File: doc/BRIEF.md
# DDR Serial Data Output Framer

This block turns a stream of parallel sample words into one serial data lane meant to be captured on both edges of a companion bit clock. A frame clock marks where each word begins. The block runs on a fast clock at twelve times the sample rate and sends one bit per fast-clock tick, most significant bit first. The bit clock toggles on every tick, so a 12-bit word spans six bit-clock periods. The receiver therefore sees a data change on every rising and every falling bit-clock edge.

A one-cycle word strobe, sampled on the fast clock, presents each new word. The strobe is taken when the lane is idle or when the last bit of the current word is on the line. Strobes in any other cycle are dropped, so a word is never cut short. When strobes come every twelve ticks the words follow each other with no gap, and both companion clocks run without a break. When no word is pending, the data line, the bit clock and the frame clock rest low.

Top module: `ddr_lane_framer`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `sdata`, `dco` and `fco` are all low after that edge. This holds even if a word was in progress, and no word is resumed after reset.
- R2: A strobe sampled high while the lane is idle loads `word_in`. Bit WORD_W-1-k of that word is driven on `sdata` during the k-th cycle after the load edge, for k = 0 to WORD_W-1 (most significant bit first, k = 0 in the cycle right after the load).
- R3: During a word, `dco` is 1 in the cycles with an even bit index (0, 2, ...) and 0 in the cycles with an odd bit index. It toggles every fast cycle and gives WORD_W/2 bit-clock periods per word.
- R4: `fco` is 1 for bit indices 0 to WORD_W/2-1 and 0 for the remaining bits. Its rising edge comes in the same cycle as the most significant bit.
- R5: A strobe sampled in the cycle that carries the last bit of a word loads the next word without a gap. Bit index 0 of the new word follows bit index WORD_W-1 of the old one directly, and `dco` and `fco` continue their patterns.
- R6: A strobe sampled while a word is on the line, in any cycle other than its last bit, is ignored. The current word finishes unchanged and no extra word is sent afterwards.
- R7: After the last bit of a word, with no new strobe taken, `sdata`, `dco` and `fco` are low in every cycle until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twelve ticks per sample period |
| rst_n | input | 1 | Synchronous active-low reset |
| word_stb | input | 1 | One-cycle strobe that presents a new sample word |
| word_in | input | WORD_W | Parallel sample word, sampled with the strobe |
| sdata | output | 1 | Serial data, one bit per fast tick, most significant bit first |
| dco | output | 1 | Bit clock: rises with even bits and falls with odd bits |
| fco | output | 1 | Frame clock: high for the first half of each word |

## Verification
A wrong bit counter shows at the ports within a single word. `fco` falls at the wrong bit, `dco` loses its alternation, or a word ends early or late, and the next strobe is then taken or dropped wrongly. A wrong shift register value shows on `sdata` in the very cycle the bad bit is due. The bench compares all three outputs on every cycle against a queue of expected triples, so any such error is reported in the cycle it first reaches a port.

// File: rtl/framer_pkg.sv
// Package: framer_pkg
// Shared constants and helpers for the DDR serial lane framer.
// Assumes word widths are even, so that a word spans whole bit-clock periods.
package framer_pkg;

    // Default sample word width, in bits
    localparam int unsigned FRAMER_WORD_W = 12;

    // Number of bit-clock periods (and frame-clock high bits) in a word
    function automatic int unsigned half_word(input int unsigned w);
        return w / 2;
    endfunction

endpackage

// File: rtl/framer_ctrl.sv
// Module: framer_ctrl
// Tracks the position of the current word on the lane and decides when a
// strobe may load a new word.
// Assumes: the strobe is a single fast-clock pulse; reset is synchronous and
// active low; WORD_W >= 2.
module framer_ctrl #(
    parameter int unsigned WORD_W = framer_pkg::FRAMER_WORD_W,
    localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_stb,
    output logic             load,
    output logic             busy,
    output logic [IDX_W-1:0] bit_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic at_last;

    // Last bit of the current word is on the line
    assign at_last = busy && (bit_idx == LAST_IDX);

    // Accept a strobe only when idle or while the last bit is on the line
    assign load = word_stb && (!busy || at_last);

    // Bit position counter and active flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            bit_idx <= '0;
        end else if (at_last) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (busy) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // R2: the bit index never leaves the word
    assert_idx_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_idx <= LAST_IDX));

    // R6: a strobe in the middle of a word only advances the position
    assert_no_midword_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !at_last && word_stb) |=> (busy && bit_idx == $past(bit_idx) + 1'b1));

    // R5: a strobe on the last bit restarts at index 0 with no idle cycle
    assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && word_stb) |=> (busy && bit_idx == '0));

endmodule

// File: rtl/framer_shift.sv
// Module: framer_shift
// Holds the word being sent and shifts it out most significant bit first,
// one bit per fast-clock tick.
// Assumes: the load and busy controls come from framer_ctrl.
module framer_shift #(
    parameter int unsigned WORD_W = framer_pkg::FRAMER_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [WORD_W-1:0] word_in,
    output logic              sdata
);

    logic [WORD_W-1:0] shreg;

    // Load on an accepted strobe, otherwise shift towards the MSB while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= word_in;
        end else if (busy) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    // The line carries the MSB of the register, and rests low when idle
    assign sdata = busy & shreg[WORD_W-1];

    // R2: the cycle after a load shows the loaded word's MSB
    assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdata == $past(word_in[WORD_W-1])));

endmodule

// File: rtl/framer_clkgen.sv
// Module: framer_clkgen
// Forms the bit clock and frame clock from the word position.
// Assumes: bit_idx counts 0..WORD_W-1 while busy, and WORD_W is even.
module framer_clkgen #(
    parameter int unsigned WORD_W = framer_pkg::FRAMER_WORD_W,
    localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1,
    localparam int unsigned HALF  = framer_pkg::half_word(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             dco,
    output logic             fco
);

    // Bit clock high on even bits, so both of its edges carry a data change
    assign dco = busy & ~bit_idx[0];

    // Frame clock high across the first half of the word
    assign fco = busy & (bit_idx < IDX_W'(HALF));

    // R3: the bit clock toggles on every tick after the first bit of a word
    assert_dco_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && bit_idx != '0) |-> (dco != $past(dco)));

    // R4: the frame clock rises only together with a bit clock rising edge
    assert_fco_rise_with_dco_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fco) |-> (dco && bit_idx == '0));

endmodule

// File: rtl/ddr_lane_framer.sv
// Module: ddr_lane_framer
// Top level of the DDR serial lane framer: a control counter, a shift
// register and a clock former, tied together.
// Assumes: clk runs at WORD_W times the sample rate; WORD_W is even, >= 2.
module ddr_lane_framer #(
    parameter int unsigned WORD_W = framer_pkg::FRAMER_WORD_W,
    localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_in,
    output logic              sdata,
    output logic              dco,
    output logic              fco
);

    logic             load;
    logic             busy;
    logic [IDX_W-1:0] bit_idx;

    // Word position and strobe acceptance
    framer_ctrl #(.WORD_W(WORD_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_stb (word_stb),
        .load     (load),
        .busy     (busy),
        .bit_idx  (bit_idx)
    );

    // Serial data path
    framer_shift #(.WORD_W(WORD_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .busy    (busy),
        .word_in (word_in),
        .sdata   (sdata)
    );

    // Companion clocks
    framer_clkgen #(.WORD_W(WORD_W)) i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .bit_idx (bit_idx),
        .dco     (dco),
        .fco     (fco)
    );

    // R7: with nothing on the line, all three outputs rest low
    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fco && !dco |-> !sdata || $past(busy));

endmodule

// File: tb/test_ddr_lane_framer.sv
module test_ddr_lane_framer;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         word_stb = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         sdata, dco, fco;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit armed = 1'b0;
    bit done = 1'b0;
    string phase = "R1";

    // expected triples {sdata, dco, fco}, front = what the line shows now
    logic [2:0] exp_q[$];

    ddr_lane_framer #(.WORD_W(W)) i_ddr_lane_framer (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_in(word_in),
        .sdata(sdata), .dco(dco), .fco(fco)
    );

    always #10 clk = ~clk;

    // reference model: advance the expected stream at each edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        armed  <= 1'b1;
        if (!rst_n) begin
            exp_q.delete();
        end else begin
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            if (word_stb && exp_q.size() == 0) begin
                for (int k = 0; k < W; k++)
                    exp_q.push_back({word_in[W-1-k], (k % 2) == 0, k < W/2});
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [2:0] e;
            string tg;
            e = (exp_q.size() > 0) ? exp_q[0] : 3'b000;
            checks++;
            if ({sdata, dco, fco} !== e) begin
                failures++;
                if (!rst_n) tg = "R1";
                else if (exp_q.size() == 0) tg = "R7";
                else if (sdata !== e[2]) tg = "R2";
                else if (dco !== e[1]) tg = "R3";
                else tg = "R4";
                $display("FAIL %s (phase %s) {sdata,dco,fco} actual=%b expected=%b",
                         tg, phase, {sdata, dco, fco}, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(input logic [W-1:0] w);
        word_stb = 1'b1;
        word_in  = w;
        @(negedge clk);
        word_stb = 1'b0;
        word_in  = ~w;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check3(input string tg, input logic [2:0] e);
        checks++;
        if ({sdata, dco, fco} !== e) begin
            failures++;
            $display("FAIL %s {sdata,dco,fco} actual=%b expected=%b",
                     tg, {sdata, dco, fco}, e);
        end
    endtask

    initial begin
        // R1: reset state
        idle(3);
        check3("R1", 3'b000);
        rst_n = 1'b1;

        // R7: idle after reset
        phase = "R7";
        idle(5);

        // R2, R3, R4: one word, then idle
        phase = "R2";
        send(12'hA53);
        check3("R4", {1'b1, 1'b1, 1'b1});
        idle(16);

        // R5: three words back to back
        phase = "R5";
        send(12'hFFF);
        idle(11);
        send(12'h000);
        check3("R5", {1'b0, 1'b1, 1'b1});
        idle(11);
        send(12'h5A5);
        check3("R5", {1'b0, 1'b1, 1'b1});
        idle(14);

        // R6: strobes in the middle of a word are dropped
        phase = "R6";
        send(12'h9C3);
        idle(2);
        send(12'h3FF);
        check3("R6", {1'b1, 1'b0, 1'b1});
        idle(3);
        send(12'hFFF);
        idle(16);

        // R5 with a one-cycle gap, then idle
        phase = "R5";
        send(12'h1E7);
        idle(12);
        send(12'hC3C);
        idle(14);

        // R1: reset in the middle of a word
        phase = "R1";
        send(12'hFFF);
        idle(4);
        rst_n = 1'b0;
        @(negedge clk);
        check3("R1", 3'b000);
        rst_n = 1'b1;
        phase = "R7";
        idle(14);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule